// File: doc/BRIEF.md
# TDMA Transmit Guardian Gate

This block sits between a node's transmitter and a shared time-division bus. It runs from a guardian clock of its own, separate from the controller clock. A round-start sync pulse aligns a local slot timer, which steps through a static table of slot lengths. The table is counted in guardian clock ticks. The gate passes the node's transmit enable and data to the bus only while the timer stands inside the node's own slot, shrunk at both ends by a guard time.

A transmit request that falls outside that window counts as a violation. A transmission that runs past the end of the window counts as one too. Either case latches the node into a fail-silent state that only reset removes. If the sync pulse stops arriving, the gate closes until a new pulse comes. The same happens before the first pulse after reset.

The slot table, node slot index and guard time are static configuration inputs, held stable during operation.

Top module: `tdma_guard_gate`

## Requirements
- R1: During and after reset, before any other stimulus, `bus_en_o`, `bus_data_o`, `viol_o` and `sync_ok_o` are all 0.
- R2: A sync pulse sampled on a clock edge puts the timer at slot 0, tick 0 in the following cycle. Slot i lasts `slot_len_i[i*LEN_W +: LEN_W]` ticks. After the last slot the timer wraps to slot 0 without needing a new pulse.
- R3: The window is open for a tick offset t inside slot `node_slot_i` when `guard_i <= t < len - guard_i`. `bus_en_o` follows `tx_en_i` combinationally while the window is open.
- R4: `bus_data_o` equals `tx_data_i` while `bus_en_o` is 1 and is 0 otherwise.
- R5: `tx_en_i` = 1 in a cycle with the window closed sets `viol_o` from the next cycle on. `bus_en_o` stays 0 in that cycle.
- R6: A transmission held past the window end is cut off in the first tick after the window. `viol_o` rises one cycle later.
- R7: Once `viol_o` is 1 it stays 1 until reset. Meanwhile `bus_en_o` is 0 even inside the window.
- R8: Let the sync pulse be captured with position 0 in the next cycle. If no further pulse comes, `sync_ok_o` stays 1 through position round+SYNC_TOL, where round is the sum of all slot lengths. It drops to 0 at position round+SYNC_TOL+1. While `sync_ok_o` is 0 the window is closed.
- R9: A sync pulse sets `sync_ok_o` in the next cycle and reopens the gate on the new timing.
- R10: Before the first sync pulse after reset the gate is closed, and a transmit request is a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Guardian clock, independent of the controller |
| grst_n | input | 1 | Asynchronous active-low reset |
| slot_len_i | input | N_SLOTS*LEN_W | Slot length table, slot i in bits [i*LEN_W +: LEN_W] |
| node_slot_i | input | IDX_W | Slot owned by this node |
| guard_i | input | LEN_W | Guard ticks at each end of the slot |
| sync_i | input | 1 | Round-start pulse |
| tx_en_i | input | 1 | Node transmit enable |
| tx_data_i | input | 1 | Node transmit data |
| bus_en_o | output | 1 | Gated bus driver enable |
| bus_data_o | output | 1 | Gated bus data |
| sync_ok_o | output | 1 | Timer is aligned to a recent round start |
| viol_o | output | 1 | Sticky fail-silent flag |

## Verification
A wrong slot index or tick count shows at the ports in the same cycle the node drives `tx_en_i`. The enable either opens at the wrong offset or stays shut, and `viol_o` answers on the next edge. For that reason the bench probes every tick offset of a round, each in a fresh run, and expects a one-cycle grant or a violation one cycle later. A faulty sync watchdog can only show as `sync_ok_o` moving at the wrong tick, so the bench checks the exact tick where it drops and the first window that follows.

// File: rtl/tdma_gg_pkg.sv
package tdma_gg_pkg;
  // window test on one slot: guard <= tick < len - guard
  function automatic logic slot_window(input logic [31:0] tick,
                                       input logic [31:0] len,
                                       input logic [31:0] guard);
    return (tick >= guard) && ((tick + guard) < len);
  endfunction
endpackage

// File: rtl/gg_slot_timer.sv
module gg_slot_timer #(
  parameter int N_SLOTS = 8,
  parameter int LEN_W   = 10,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_i,
  input  logic [N_SLOTS*LEN_W-1:0] slot_len_i,
  output logic [IDX_W-1:0]         slot_idx_o,
  output logic [LEN_W-1:0]         slot_tick_o,
  output logic [LEN_W-1:0]         cur_len_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] tick_q, tick_d;

  assign cur_len_o = slot_len_i[idx_q*LEN_W +: LEN_W];

  always_comb begin
    idx_d  = idx_q;
    tick_d = tick_q + 1'b1;
    if (sync_i) begin
      idx_d  = '0;
      tick_d = '0;
    end else if ({1'b0, tick_q} + 1'b1 >= {1'b0, cur_len_o}) begin
      tick_d = '0;
      idx_d  = (idx_q == IDX_W'(N_SLOTS - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      tick_q <= '0;
    end else begin
      idx_q  <= idx_d;
      tick_q <= tick_d;
    end
  end

  assign slot_idx_o  = idx_q;
  assign slot_tick_o = tick_q;
endmodule

// File: rtl/gg_sync_watch.sv
module gg_sync_watch #(
  parameter int CNT_W    = 16,
  parameter int SYNC_TOL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] round_len_i,
  output logic             synced_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             ok_q, ok_d;

  assign limit = round_len_i + CNT_W'(SYNC_TOL);

  always_comb begin
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (sync_i) begin
      cnt_d = '0;
      ok_d  = 1'b1;
    end else if (cnt_q < limit) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      ok_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign synced_o = ok_q;
endmodule

// File: rtl/gg_window.sv
module gg_window #(
  parameter int LEN_W = 10,
  parameter int IDX_W = 3
) (
  input  logic             synced_i,
  input  logic [IDX_W-1:0] slot_idx_i,
  input  logic [IDX_W-1:0] node_slot_i,
  input  logic [LEN_W-1:0] tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] guard_i,
  output logic             open_o
);
  import tdma_gg_pkg::*;
  always_comb begin
    open_o = synced_i && (slot_idx_i == node_slot_i) &&
             slot_window(32'(tick_i), 32'(len_i), 32'(guard_i));
  end
endmodule

// File: rtl/tdma_guard_gate.sv
module tdma_guard_gate #(
  parameter int N_SLOTS  = 8,
  parameter int LEN_W    = 10,
  parameter int SYNC_TOL = 8,
  localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CNT_W   = LEN_W + IDX_W + 2
) (
  input  logic                     gclk,
  input  logic                     grst_n,
  input  logic [N_SLOTS*LEN_W-1:0] slot_len_i,
  input  logic [IDX_W-1:0]         node_slot_i,
  input  logic [LEN_W-1:0]         guard_i,
  input  logic                     sync_i,
  input  logic                     tx_en_i,
  input  logic                     tx_data_i,
  output logic                     bus_en_o,
  output logic                     bus_data_o,
  output logic                     sync_ok_o,
  output logic                     viol_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge gclk or negedge grst_n) begin
    if (!grst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [IDX_W-1:0] slot_idx;
  logic [LEN_W-1:0] slot_tick, cur_len;
  logic [CNT_W-1:0] round_len;
  logic             synced, win_open;
  logic             viol_q, viol_d;

  always_comb begin
    round_len = '0;
    for (int i = 0; i < N_SLOTS; i++)
      round_len = round_len + CNT_W'(slot_len_i[i*LEN_W +: LEN_W]);
  end

  gg_slot_timer #(.N_SLOTS(N_SLOTS), .LEN_W(LEN_W)) u_timer (
    .clk(gclk), .rst_n(rst_n_s), .sync_i(sync_i), .slot_len_i(slot_len_i),
    .slot_idx_o(slot_idx), .slot_tick_o(slot_tick), .cur_len_o(cur_len));

  gg_sync_watch #(.CNT_W(CNT_W), .SYNC_TOL(SYNC_TOL)) u_watch (
    .clk(gclk), .rst_n(rst_n_s), .sync_i(sync_i), .round_len_i(round_len),
    .synced_o(synced));

  gg_window #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_win (
    .synced_i(synced), .slot_idx_i(slot_idx), .node_slot_i(node_slot_i),
    .tick_i(slot_tick), .len_i(cur_len), .guard_i(guard_i), .open_o(win_open));

  always_comb viol_d = viol_q | (tx_en_i & ~win_open);

  always_ff @(posedge gclk or negedge rst_n_s) begin
    if (!rst_n_s) viol_q <= 1'b0;
    else          viol_q <= viol_d;
  end

  assign bus_en_o   = tx_en_i & win_open & ~viol_q;
  assign bus_data_o = bus_en_o & tx_data_i;
  assign sync_ok_o  = synced;
  assign viol_o     = viol_q;
endmodule

// File: rtl/tdma_guard_gate_chk.sv
module tdma_guard_gate_chk #(
  parameter int LEN_W = 10,
  parameter int IDX_W = 3
) (
  input logic             gclk,
  input logic             rst_n_s,
  input logic             sync_i,
  input logic             tx_en_i,
  input logic             bus_en_o,
  input logic             bus_data_o,
  input logic             sync_ok_o,
  input logic             viol_o,
  input logic [IDX_W-1:0] slot_idx,
  input logic [IDX_W-1:0] node_slot_i,
  input logic [LEN_W-1:0] slot_tick,
  input logic [LEN_W-1:0] guard_i
);
  AST_SYNC_ALIGN: assert property (@(posedge gclk) disable iff (!rst_n_s)
    sync_i |=> (slot_idx == '0 && slot_tick == '0));                      // R2
  AST_OWN_SLOT: assert property (@(posedge gclk) disable iff (!rst_n_s)
    bus_en_o |-> (slot_idx == node_slot_i && slot_tick >= guard_i));      // R3
  AST_DATA_QUIET: assert property (@(posedge gclk) disable iff (!rst_n_s)
    !bus_en_o |-> !bus_data_o);                                           // R4
  AST_VIOL_CAUSE: assert property (@(posedge gclk) disable iff (!rst_n_s)
    $rose(viol_o) |-> $past(tx_en_i && !bus_en_o));                       // R5
  AST_VIOL_STICKY: assert property (@(posedge gclk) disable iff (!rst_n_s)
    viol_o |=> viol_o);                                                   // R7
  AST_SILENT: assert property (@(posedge gclk) disable iff (!rst_n_s)
    viol_o |-> !bus_en_o);                                                // R7
  AST_UNSYNC_SHUT: assert property (@(posedge gclk) disable iff (!rst_n_s)
    !sync_ok_o |-> !bus_en_o);                                            // R8
  AST_RESYNC: assert property (@(posedge gclk) disable iff (!rst_n_s)
    sync_i |=> sync_ok_o);                                                // R9
endmodule

bind tdma_guard_gate tdma_guard_gate_chk #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
  .gclk(gclk), .rst_n_s(rst_n_s), .sync_i(sync_i), .tx_en_i(tx_en_i),
  .bus_en_o(bus_en_o), .bus_data_o(bus_data_o), .sync_ok_o(sync_ok_o),
  .viol_o(viol_o), .slot_idx(slot_idx), .node_slot_i(node_slot_i),
  .slot_tick(slot_tick), .guard_i(guard_i));

// File: tb/test_tdma_guard_gate.sv
module test_tdma_guard_gate;
  localparam int NS = 4, LW = 6, TOL = 16, IW = 2;
  localparam int RL = 44, NODE = 1, GUARD = 2;

  logic gclk = 1'b0, grst_n = 1'b0;
  logic [NS*LW-1:0] slot_len;
  logic sync_p = 1'b0, tx_en = 1'b0, tx_data = 1'b0;
  logic bus_en, bus_data, sync_ok, viol;
  int   n_tests = 0, n_fail = 0, cyc = 0;
  bit   done = 0;

  always #5 gclk = ~gclk;

  tdma_guard_gate #(.N_SLOTS(NS), .LEN_W(LW), .SYNC_TOL(TOL)) i_tdma_guard_gate (
    .gclk(gclk), .grst_n(grst_n), .slot_len_i(slot_len),
    .node_slot_i(IW'(NODE)), .guard_i(LW'(GUARD)), .sync_i(sync_p),
    .tx_en_i(tx_en), .tx_data_i(tx_data), .bus_en_o(bus_en),
    .bus_data_o(bus_data), .sync_ok_o(sync_ok), .viol_o(viol));

  function automatic int len_of(int s);
    case (s) 0: return 10; 1: return 12; 2: return 8; default: return 14;
    endcase
  endfunction

  // expected window from the slot table, position counted from sync
  function automatic bit exp_win(int pos);
    int q = pos % RL;
    int base = 0;
    for (int s = 0; s < NS; s++) begin
      if (q < base + len_of(s))
        return (s == NODE) && (q - base >= GUARD) && (q - base + GUARD < len_of(s));
      base += len_of(s);
    end
    return 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    grst_n = 1'b0; tx_en = 1'b0; sync_p = 1'b0;
    repeat (2) @(negedge gclk);
    grst_n = 1'b1;
    repeat (3) @(negedge gclk);
  endtask

  // leaves the bench at position 0 (first cycle after the captured pulse)
  task automatic do_sync();
    sync_p = 1'b1;
    @(negedge gclk);
    sync_p = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge gclk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) slot_len[s*LW +: LW] = LW'(len_of(s));
    #1;
    check("R1 bus_en in reset", bus_en, 1'b0);
    check("R1 viol in reset", viol, 1'b0);
    do_reset();
    check("R1 bus_en", bus_en, 1'b0);
    check("R1 bus_data", bus_data, 1'b0);
    check("R1 sync_ok", sync_ok, 1'b0);
    check("R1 viol", viol, 1'b0);

    // R10: request before any sync
    tx_en = 1'b1; tx_data = 1'b1; #1;
    check("R10 closed before sync", bus_en, 1'b0);
    @(negedge gclk); tx_en = 1'b0;
    check("R10 violation before sync", viol, 1'b1);

    // R3 R5 R4: one-cycle request at every offset of a round, fresh run each
    for (int p = 0; p < RL + 2; p++) begin
      do_reset();
      do_sync();
      check("R9 sync_ok after pulse", sync_ok, 1'b1);
      repeat (p) @(negedge gclk);
      tx_en = 1'b1; tx_data = p[0]; #1;
      check("R3 window at offset", bus_en, exp_win(p));
      check("R4 data follows", bus_data, exp_win(p) & p[0]);
      @(negedge gclk); tx_en = 1'b0;
      check("R5 violation iff outside", viol, !exp_win(p));
    end

    // R6 overlong transmission, R7 sticky
    do_reset();
    do_sync();
    repeat (12) @(negedge gclk);
    tx_en = 1'b1;
    for (int p = 12; p < 20; p++) begin
      tx_data = ~p[0]; #1;
      check("R6 granted inside window", bus_en, 1'b1);
      check("R4 data inside window", bus_data, ~p[0]);
      @(negedge gclk);
    end
    #1;
    check("R6 cut at window end", bus_en, 1'b0);
    check("R6 no violation yet", viol, 1'b0);
    @(negedge gclk); tx_en = 1'b0;
    check("R6 violation after overrun", viol, 1'b1);
    do_sync();
    repeat (12) @(negedge gclk);
    tx_en = 1'b1; #1;
    check("R7 blocked in next window", bus_en, 1'b0);
    @(negedge gclk); tx_en = 1'b0;
    check("R7 still set", viol, 1'b1);

    // R2 wrap without sync, R8 loss of sync
    do_reset();
    do_sync();
    repeat (RL + 12) @(negedge gclk);
    tx_en = 1'b1; #1;
    check("R2 window after wrap", bus_en, 1'b1);
    @(negedge gclk); tx_en = 1'b0;
    check("R2 no violation after wrap", viol, 1'b0);
    repeat (RL + TOL - (RL + 13)) @(negedge gclk);
    check("R8 sync held to limit", sync_ok, 1'b1);
    @(negedge gclk);
    check("R8 sync lost after limit", sync_ok, 1'b0);
    tx_en = 1'b1; #1;
    check("R8 closed while unsynced", bus_en, 1'b0);
    @(negedge gclk); tx_en = 1'b0;
    check("R8 violation while unsynced", viol, 1'b1);

    // R9 resync after loss reopens the gate
    do_reset();
    do_sync();
    repeat (RL + TOL + 1) @(negedge gclk);
    check("R8 lost", sync_ok, 1'b0);
    do_sync();
    check("R9 sync restored", sync_ok, 1'b1);
    repeat (12) @(negedge gclk);
    tx_en = 1'b1; tx_data = 1'b1; #1;
    check("R9 window reopened", bus_en, 1'b1);
    check("R9 data reopened", bus_data, 1'b1);
    @(negedge gclk); tx_en = 1'b0;
    check("R9 no violation", viol, 1'b0);

    finish_run();
  end
endmodule